// File: doc/BRIEF.md
# NAND Cache Page-Read Sequencer

This block drives page reads on one NAND die by issuing a stream of single-byte bus cycles (command, address, data read) to an external bus cycle engine. It packs a row (page, plane, block, die select) into five address bytes, issues the load and cache-read commands, polls the ready line after every operation that makes the die busy, and delivers each page as a byte stream with an end-of-page flag.

Three run shapes use the cache register pipeline. The device loads the next page into its data register while the sequencer drains the current page from the cache register. A sequential run walks consecutive pages from one start address. A random run accepts a new row through the request handshake before each cache-read command. A two-plane run loads one page from each plane at the same time and then drains the two planes in turn. A plain one-page read is also provided.

Top module: `nand_cache_reader`

## Requirements
- R1: Every address phase is five ADDR cycles, least significant byte first, carrying a 40-bit word: column in bits 13:0 (always zero), page in 21:14, plane in 22, block in 33:23, die select in 34, and zero above.
- R2: A plain read (mode 0) issues command 0x00, the five address bytes and command 0x30, waits for ready, and then reads one page. Each bus cycle holds its kind and byte until acknowledged.
- R3: After a command that makes the die busy (0x30, 0x31, 0x32, 0x3F), no bus cycle is requested until the sequencer has waited WB_CYCLES cycles and then sampled nand_rdy high.
- R4: Each acknowledged READ cycle yields one out_valid byte, one cycle later, carrying the returned data. out_last is set on byte 8639 of each page (8192 data plus 448 spare) and on no other byte.
- R5: A sequential run (mode 1) of N >= 2 pages issues 0x00, the address and 0x30. It then issues N-1 bare 0x31 commands and a final 0x3F, and streams one page after each of these commands, N pages in total.
- R6: A sequential request for N <= 1 pages runs exactly as a plain read.
- R7: A random run (mode 2) loads its first row with 0x00/address/0x30. While the accepted row is not flagged last, it takes the next row through the request handshake, issues 0x00/address/0x31, and streams the previous page. Once the last-flagged row is loaded, it issues 0x3F and streams the final page.
- R8: A two-plane run (mode 3) forces the plane bit and issues 0x00/addr(plane 0)/0x32, wait, 0x00/addr(plane 1)/0x30, wait. It then issues 0x06/addr(plane 0)/0xE0, streams that page, issues 0x06/addr(plane 1)/0xE0 and streams that page. The requested plane bit is ignored.
- R9: req_ready is high only while idle or while a random run waits for its next row. A req_valid held high at any other time starts nothing and issues nothing.
- R10: Out of reset req_ready is high and cyc_req and out_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request or next random row offered |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_mode | input | 2 | 0 plain, 1 sequential, 2 random, 3 two-plane |
| req_page | input | 8 | Page within block |
| req_plane | input | 1 | Plane select |
| req_block | input | 11 | Block number |
| req_lun | input | 1 | Die select |
| req_pages | input | CNT_W | Page count for sequential runs |
| req_last | input | 1 | Random run: this row is the final one |
| cyc_req | output | 1 | Bus cycle requested |
| cyc_kind | output | 2 | 0 command, 1 address, 2 data read |
| cyc_byte | output | 8 | Command or address byte |
| cyc_ack | input | 1 | Engine completes the cycle this clock |
| cyc_rdata | input | 8 | Byte returned with a read acknowledge |
| nand_rdy | input | 1 | Die ready (high) or busy (low) |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Page byte |
| out_last | output | 1 | Final byte of a page |

## Verification
A wrong run-shape decision shows on the command log within one operation: an extra or missing 0x31/0x3F, or a 0xE0 where a busy wait belongs. It then shows on the page stream as a page repeated or skipped, because the bench's device model returns a byte pattern unique to each row. A wrong address packing shows in the fifth address cycle of the first operation. A page counter off by one moves out_last and shifts every later byte, so the first page compared exposes it. A premature ready poll shows as a bus cycle requested while the model holds nand_rdy low.

// File: rtl/nrd_pkg.sv
`timescale 1ns/1ps
package nrd_pkg;
  localparam int PG_W     = 8;
  localparam int BLK_W    = 11;
  localparam int LUN_W    = 1;
  localparam int COL_W    = 14;
  localparam int ADDR_CYC = 5;

  typedef enum logic [1:0] {CYC_CMD = 2'd0, CYC_ADDR = 2'd1, CYC_READ = 2'd2} cyc_kind_e;
  typedef enum logic [1:0] {RD_PLAIN = 2'd0, RD_SEQ = 2'd1, RD_RAND = 2'd2, RD_DUAL = 2'd3} rd_mode_e;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPEN, ST_ADDR, ST_CONF, ST_WAIT, ST_STREAM, ST_STEP, ST_NEXTA
  } seq_st_e;

  typedef struct packed {
    logic [LUN_W-1:0] lun;
    logic [BLK_W-1:0] blk;
    logic             plane;
    logic [PG_W-1:0]  page;
  } row_t;

  localparam logic [7:0] OP_LOAD    = 8'h00;
  localparam logic [7:0] OP_COLSEL  = 8'h06;
  localparam logic [7:0] OP_GO      = 8'h30;
  localparam logic [7:0] OP_CACHE   = 8'h31;
  localparam logic [7:0] OP_PLANE   = 8'h32;
  localparam logic [7:0] OP_CLOSE   = 8'h3F;
  localparam logic [7:0] OP_COLGO   = 8'hE0;
endpackage

// File: rtl/nrd_addr_pack.sv
`timescale 1ns/1ps
module nrd_addr_pack
  import nrd_pkg::*;
#(
  parameter int N_CYC = ADDR_CYC
) (
  input  row_t                       row,
  input  logic [$clog2(N_CYC)-1:0]   idx,
  output logic [7:0]                 abyte
);
  localparam int ALL_W = N_CYC * 8;
  localparam int PAD_W = ALL_W - COL_W - $bits(row_t);

  logic [ALL_W-1:0] word;

  assign word  = {{PAD_W{1'b0}}, row, {COL_W{1'b0}}};
  assign abyte = word[int'(idx)*8 +: 8];
endmodule

// File: rtl/nrd_stream.sv
`timescale 1ns/1ps
module nrd_stream #(
  parameter int PAGE_BYTES = 8640
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic [7:0] rdata,
  output logic       page_end,
  output logic       out_valid,
  output logic       out_data_en,
  output logic [7:0] out_data,
  output logic       out_last
);
  localparam int CW = $clog2(PAGE_BYTES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_end;

  assign at_end      = (cnt_q == CW'(PAGE_BYTES - 1));
  assign page_end    = take && at_end;
  assign cnt_d       = at_end ? '0 : cnt_q + CW'(1);
  assign out_data_en = take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      if (take) cnt_q <= cnt_d;
      out_valid <= take;
      out_last  <= page_end;
    end
  end

  always_ff @(posedge clk) begin
    if (out_data_en) out_data <= rdata;
  end

  assert_last_has_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  assert_count_wraps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> cnt_q == '0);
endmodule

// File: rtl/nand_cache_reader.sv
`timescale 1ns/1ps
module nand_cache_reader
  import nrd_pkg::*;
#(
  parameter int PAGE_DATA  = 8192,
  parameter int PAGE_SPARE = 448,
  parameter int WB_CYCLES  = 4,
  parameter int CNT_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_mode,
  input  logic [PG_W-1:0]      req_page,
  input  logic                 req_plane,
  input  logic [BLK_W-1:0]     req_block,
  input  logic [LUN_W-1:0]     req_lun,
  input  logic [CNT_W-1:0]     req_pages,
  input  logic                 req_last,
  output logic                 cyc_req,
  output logic [1:0]           cyc_kind,
  output logic [7:0]           cyc_byte,
  input  logic                 cyc_ack,
  input  logic [7:0]           cyc_rdata,
  input  logic                 nand_rdy,
  output logic                 out_valid,
  output logic [7:0]           out_data,
  output logic                 out_last
);
  localparam int PAGE_BYTES = PAGE_DATA + PAGE_SPARE;
  localparam int WB_W       = $clog2(WB_CYCLES + 1);
  localparam int AI_W       = $clog2(ADDR_CYC);

  seq_st_e          st_q, st_d;
  rd_mode_e         mode_q, mode_d;
  row_t             row_q, row_d, req_row;
  logic             row_en;
  logic [CNT_W-1:0] left_q, left_d;
  logic             last_q, last_d;
  logic             close_q, close_d;
  logic             tostr_q, tostr_d;
  logic [7:0]       open_q, open_d;
  logic [7:0]       conf_q, conf_d;
  logic [1:0]       dph_q, dph_d;
  logic [AI_W-1:0]  aidx_q, aidx_d;
  logic [WB_W-1:0]  wb_q, wb_d;
  logic [7:0]       addr_byte;
  logic             take, page_end, out_data_en;
  logic             one_shot;

  assign req_row  = '{lun: req_lun, blk: req_block, plane: req_plane, page: req_page};
  assign one_shot = (rd_mode_e'(req_mode) == RD_PLAIN) ||
                    (rd_mode_e'(req_mode) == RD_SEQ  && req_pages <= CNT_W'(1)) ||
                    (rd_mode_e'(req_mode) == RD_RAND && req_last);

  nrd_addr_pack #(.N_CYC(ADDR_CYC)) u_pack (
    .row   (row_q),
    .idx   (aidx_q),
    .abyte (addr_byte)
  );

  nrd_stream #(.PAGE_BYTES(PAGE_BYTES)) u_stream (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (take),
    .rdata       (cyc_rdata),
    .page_end    (page_end),
    .out_valid   (out_valid),
    .out_data_en (out_data_en),
    .out_data    (out_data),
    .out_last    (out_last)
  );

  // Next-state process
  always_comb begin
    st_d     = st_q;
    mode_d   = mode_q;
    row_d    = row_q;
    row_en   = 1'b0;
    left_d   = left_q;
    last_d   = last_q;
    close_d  = close_q;
    tostr_d  = tostr_q;
    open_d   = open_q;
    conf_d   = conf_q;
    dph_d    = dph_q;
    aidx_d   = aidx_q;
    wb_d     = wb_q;
    req_ready = 1'b0;
    cyc_req   = 1'b0;
    cyc_kind  = CYC_CMD;
    cyc_byte  = 8'h00;
    take      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          row_d  = req_row;
          row_en = 1'b1;
          mode_d = rd_mode_e'(req_mode);
          left_d = req_pages;
          last_d = req_last;
          dph_d  = 2'd0;
          if (rd_mode_e'(req_mode) == RD_DUAL) begin
            close_d = 1'b0;
            st_d    = ST_STEP;
          end else begin
            open_d  = OP_LOAD;
            conf_d  = OP_GO;
            close_d = one_shot;
            tostr_d = one_shot;
            st_d    = ST_OPEN;
          end
        end
      end
      ST_OPEN: begin
        cyc_req  = 1'b1;
        cyc_byte = open_q;
        if (cyc_ack) begin
          aidx_d = '0;
          st_d   = ST_ADDR;
        end
      end
      ST_ADDR: begin
        cyc_req  = 1'b1;
        cyc_kind = CYC_ADDR;
        cyc_byte = addr_byte;
        if (cyc_ack) begin
          if (aidx_q == AI_W'(ADDR_CYC - 1)) st_d = ST_CONF;
          else aidx_d = aidx_q + AI_W'(1);
        end
      end
      ST_CONF: begin
        cyc_req  = 1'b1;
        cyc_byte = conf_q;
        if (cyc_ack) begin
          wb_d = '0;
          st_d = (conf_q == OP_COLGO) ? ST_STREAM : ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (wb_q != WB_W'(WB_CYCLES)) wb_d = wb_q + WB_W'(1);
        else if (nand_rdy) st_d = tostr_q ? ST_STREAM : ST_STEP;
      end
      ST_STREAM: begin
        cyc_req  = 1'b1;
        cyc_kind = CYC_READ;
        take     = cyc_ack;
        if (page_end) begin
          left_d = left_q - CNT_W'(1);
          st_d   = close_q ? ST_IDLE : ST_STEP;
        end
      end
      ST_STEP: begin
        unique case (mode_q)
          RD_SEQ: begin
            conf_d  = (left_q == CNT_W'(1)) ? OP_CLOSE : OP_CACHE;
            close_d = (left_q == CNT_W'(1));
            tostr_d = 1'b1;
            st_d    = ST_CONF;
          end
          RD_RAND: begin
            if (last_q) begin
              conf_d  = OP_CLOSE;
              close_d = 1'b1;
              tostr_d = 1'b1;
              st_d    = ST_CONF;
            end else begin
              st_d = ST_NEXTA;
            end
          end
          RD_DUAL: begin
            row_d       = row_q;
            row_d.plane = dph_q[0];
            row_en      = 1'b1;
            open_d      = dph_q[1] ? OP_COLSEL : OP_LOAD;
            conf_d      = dph_q[1] ? OP_COLGO : (dph_q[0] ? OP_GO : OP_PLANE);
            tostr_d     = 1'b0;
            close_d     = (dph_q == 2'd3);
            dph_d       = dph_q + 2'd1;
            st_d        = ST_OPEN;
          end
          default: st_d = ST_IDLE;
        endcase
      end
      ST_NEXTA: begin
        req_ready = 1'b1;
        if (req_valid) begin
          row_d   = req_row;
          row_en  = 1'b1;
          last_d  = req_last;
          open_d  = OP_LOAD;
          conf_d  = OP_CACHE;
          tostr_d = 1'b1;
          st_d    = ST_OPEN;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      mode_q  <= RD_PLAIN;
      row_q   <= '0;
      left_q  <= '0;
      last_q  <= 1'b0;
      close_q <= 1'b0;
      tostr_q <= 1'b0;
      open_q  <= OP_LOAD;
      conf_q  <= OP_GO;
      dph_q   <= 2'd0;
      aidx_q  <= '0;
      wb_q    <= '0;
    end else begin
      st_q    <= st_d;
      mode_q  <= mode_d;
      if (row_en) row_q <= row_d;
      left_q  <= left_d;
      last_q  <= last_d;
      close_q <= close_d;
      tostr_q <= tostr_d;
      open_q  <= open_d;
      conf_q  <= conf_d;
      dph_q   <= dph_d;
      aidx_q  <= aidx_d;
      wb_q    <= wb_d;
    end
  end

  assert_cycle_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_req && !cyc_ack |=> cyc_req && $stable(cyc_kind) && $stable(cyc_byte));
  assert_addr_then_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_req && cyc_ack && cyc_kind == CYC_ADDR && aidx_q == AI_W'(ADDR_CYC - 1)
      |=> cyc_req && cyc_kind == CYC_CMD);
  assert_ready_before_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cyc_req) && $past(st_q) == ST_WAIT |-> $past(nand_rdy));
  assert_no_bus_when_accepting_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cyc_req);
endmodule

// File: tb/test_nand_cache_reader.sv
`timescale 1ns/1ps
module test_nand_cache_reader;
  localparam int CLK_PERIOD = 10;
  localparam int PB         = 8640;
  localparam int BUSY_CYC   = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_plane, req_last;
  logic [1:0]  req_mode;
  logic [7:0]  req_page;
  logic [10:0] req_block;
  logic [0:0]  req_lun;
  logic [7:0]  req_pages;
  logic        cyc_req, cyc_ack;
  logic [1:0]  cyc_kind;
  logic [7:0]  cyc_byte, cyc_rdata;
  logic        nand_rdy;
  logic        out_valid, out_last;
  logic [7:0]  out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_cache_reader i_nand_cache_reader (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode),
    .req_page(req_page), .req_plane(req_plane), .req_block(req_block),
    .req_lun(req_lun), .req_pages(req_pages), .req_last(req_last),
    .cyc_req(cyc_req), .cyc_kind(cyc_kind), .cyc_byte(cyc_byte),
    .cyc_ack(cyc_ack), .cyc_rdata(cyc_rdata), .nand_rdy(nand_rdy),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

  int checks = 0;
  int errors = 0;
  logic mon_clr = 1'b0;

  // row = {lun, block[10:0], plane, page[7:0]}
  function automatic logic [7:0] pat(logic [20:0] row, int idx);
    int v;
    v = int'(row[7:0]) + int'(row[15:8]) * 3 + int'(row[20:16]) * 5 + idx * 7 + (idx >> 8);
    return v[7:0];
  endfunction

  // ---------------- device model ----------------
  logic [9:0]  log_mem [0:63];
  int          log_n, busy_viol, m_busy, m_an, m_ridx;
  logic [20:0] m_row, m_out, m_data, m_pend_row;
  logic [20:0] m_dual [0:1];
  logic [39:0] m_asr;
  logic        m_fresh, m_pend;

  assign cyc_ack   = cyc_req;
  assign cyc_rdata = pat(m_out, m_ridx);

  always @(posedge clk) begin
    if (!rst_n || mon_clr) begin
      log_n <= 0; busy_viol <= 0;
      if (!rst_n) begin
        nand_rdy <= 1'b1; m_busy <= 0; m_an <= 0; m_ridx <= 0; m_fresh <= 1'b0;
        m_pend <= 1'b0; m_row <= '0; m_out <= '0; m_data <= '0; m_asr <= '0;
        m_pend_row <= '0; m_dual[0] <= '0; m_dual[1] <= '0;
      end
    end else begin
      if (m_busy > 0) begin
        m_busy <= m_busy - 1;
        if (m_busy == 1) nand_rdy <= 1'b1;
      end
      if (cyc_req && cyc_ack) begin
        if (!nand_rdy) busy_viol <= busy_viol + 1;
        if (cyc_kind == 2'd2) m_ridx <= m_ridx + 1;
        else begin
          log_mem[log_n] <= {cyc_kind, cyc_byte};
          log_n <= log_n + 1;
        end
        if (cyc_kind == 2'd1) begin : addr_in
          automatic logic [39:0] t = m_asr;
          t[m_an*8 +: 8] = cyc_byte;
          m_asr <= t;
          m_an  <= m_an + 1;
          if (m_an == 4) begin m_row <= t[34:14]; m_fresh <= 1'b1; end
        end
        if (cyc_kind == 2'd0) begin
          case (cyc_byte)
            8'h00, 8'h06: m_an <= 0;
            8'h30: begin
              if (m_pend) begin m_dual[m_pend_row[8]] <= m_pend_row; m_pend <= 1'b0; end
              m_dual[m_row[8]] <= m_row;
              m_out <= m_row; m_data <= m_row;
            end
            8'h31: begin m_out <= m_data; m_data <= m_fresh ? m_row : m_data + 21'd1; end
            8'h3F: m_out <= m_data;
            8'h32: begin m_pend <= 1'b1; m_pend_row <= m_row; end
            8'hE0: m_out <= m_dual[m_row[8]];
            default: ;
          endcase
          if (cyc_byte inside {8'h30, 8'h31, 8'h3F, 8'h32, 8'hE0}) begin
            m_ridx <= 0; m_fresh <= 1'b0;
          end
          if (cyc_byte inside {8'h30, 8'h31, 8'h3F, 8'h32}) begin
            m_busy <= BUSY_CYC; nand_rdy <= 1'b0;
          end
        end
      end
    end
  end

  // ---------------- stream monitor ----------------
  logic [20:0] exp_rows [0:7];
  int n_rows, pg, bidx, byte_err, last_err;

  always @(negedge clk) begin
    if (!rst_n || mon_clr) begin
      pg <= 0; bidx <= 0; byte_err <= 0; last_err <= 0;
    end else if (out_valid) begin
      if (pg >= n_rows || out_data != pat(exp_rows[pg], bidx)) byte_err <= byte_err + 1;
      if (out_last != (bidx == PB - 1)) last_err <= last_err + 1;
      if (out_last) begin pg <= pg + 1; bidx <= 0; end
      else bidx <= bidx + 1;
    end
  end

  // ---------------- helpers ----------------
  logic [9:0] exp_mem [0:63];
  int exp_n;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ec(input logic [7:0] b);
    exp_mem[exp_n] = {2'd0, b}; exp_n++;
  endtask

  task automatic ea(input logic [20:0] row);
    logic [39:0] a;
    a = (40'(row[7:0]) << 14) | (40'(row[8]) << 22) | (40'(row[19:9]) << 23) | (40'(row[20]) << 34);
    for (int i = 0; i < 5; i++) begin exp_mem[exp_n] = {2'd1, a[i*8 +: 8]}; exp_n++; end
  endtask

  task automatic fresh_run();
    @(posedge clk); #1 mon_clr = 1'b1;
    @(posedge clk); #1 mon_clr = 1'b0;
    exp_n = 0; n_rows = 0;
  endtask

  task automatic issue(input logic [1:0] mode, input logic [20:0] row,
                       input logic [7:0] pages, input bit last);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_mode = mode; req_page = row[7:0]; req_plane = row[8];
    req_block = row[19:9]; req_lun = row[20]; req_pages = pages; req_last = last;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_run(input string tag);
    int t = 0;
    @(negedge clk);
    while (!(pg == n_rows && req_ready && !cyc_req) && t < 60000) begin
      @(negedge clk); t++;
    end
    if (t >= 60000) begin
      errors++; checks++;
      $display("FAIL %s watchdog actual=%0d expected=%0d", tag, pg, n_rows);
    end
  endtask

  task automatic check_run(input string tag);
    int bad = -1;
    chk(log_n == exp_n, {tag, " bus cycle count"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (bad < 0 && log_mem[i] != exp_mem[i]) bad = i;
    if (bad >= 0) chk(1'b0, {tag, " bus cycle value"}, int'(log_mem[bad]), int'(exp_mem[bad]));
    else chk(1'b1, tag, 0, 0);
    chk(pg == n_rows, {tag, " pages streamed"}, pg, n_rows);
    chk(byte_err == 0, {tag, " page bytes R4"}, byte_err, 0);
    chk(last_err == 0, {tag, " last flag R4"}, last_err, 0);
    chk(busy_viol == 0, {tag, " cycle while busy R3"}, busy_viol, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_R10();
    chk(req_ready == 1'b1, "R10 req_ready", int'(req_ready), 1);
    chk(cyc_req == 1'b0, "R10 cyc_req", int'(cyc_req), 0);
    chk(out_valid == 1'b0, "R10 out_valid", int'(out_valid), 0);
  endtask

  task automatic t_plain_R2(input logic [20:0] row, input string tag);
    fresh_run();
    exp_rows[0] = row; n_rows = 1;
    ec(8'h00); ea(row); ec(8'h30);
    issue(2'd0, row, 8'd0, 1'b0);
    wait_run(tag);
    check_run(tag);
  endtask

  task automatic t_seq_R5_R9();
    logic [20:0] r = {1'b0, 11'd77, 1'b0, 8'd10};
    fresh_run();
    for (int i = 0; i < 3; i++) exp_rows[i] = r + 21'(i);
    n_rows = 3;
    ec(8'h00); ea(r); ec(8'h30); ec(8'h31); ec(8'h31); ec(8'h3F);
    issue(2'd1, r, 8'd3, 1'b0);
    // R9: offer a junk request while the run is busy
    req_valid = 1'b1; req_mode = 2'd0; req_page = 8'hAA; req_block = 11'd5;
    while (pg < 2) @(negedge clk);
    req_valid = 1'b0;
    wait_run("R5 sequential");
    check_run("R5 sequential (R9 junk request ignored)");
  endtask

  task automatic t_seq_one_R6();
    logic [20:0] r = {1'b1, 11'd300, 1'b1, 8'd200};
    fresh_run();
    exp_rows[0] = r; n_rows = 1;
    ec(8'h00); ea(r); ec(8'h30);
    issue(2'd1, r, 8'd1, 1'b0);
    wait_run("R6 one-page sequential");
    check_run("R6 one-page sequential");
  endtask

  task automatic t_rand_R7();
    logic [20:0] a = {1'b0, 11'd12, 1'b1, 8'd3};
    logic [20:0] b = {1'b1, 11'd900, 1'b0, 8'd250};
    logic [20:0] c = {1'b0, 11'd1, 1'b0, 8'd0};
    fresh_run();
    exp_rows[0] = a; exp_rows[1] = b; exp_rows[2] = c; n_rows = 3;
    ec(8'h00); ea(a); ec(8'h30);
    ec(8'h00); ea(b); ec(8'h31);
    ec(8'h00); ea(c); ec(8'h31);
    ec(8'h3F);
    issue(2'd2, a, 8'd0, 1'b0);
    issue(2'd0, b, 8'd0, 1'b0);
    issue(2'd0, c, 8'd0, 1'b1);
    wait_run("R7 random");
    check_run("R7 random");
  endtask

  task automatic t_dual_R8();
    logic [20:0] r  = {1'b0, 11'd100, 1'b1, 8'd9};
    logic [20:0] r0 = {1'b0, 11'd100, 1'b0, 8'd9};
    fresh_run();
    exp_rows[0] = r0; exp_rows[1] = r; n_rows = 2;
    ec(8'h00); ea(r0); ec(8'h32);
    ec(8'h00); ea(r);  ec(8'h30);
    ec(8'h06); ea(r0); ec(8'hE0);
    ec(8'h06); ea(r);  ec(8'hE0);
    issue(2'd3, r, 8'd0, 1'b0);
    wait_run("R8 two-plane");
    check_run("R8 two-plane");
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    $display("FAIL global watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_mode = '0; req_page = '0; req_plane = 1'b0;
    req_block = '0; req_lun = '0; req_pages = '0; req_last = 1'b0; n_rows = 0; exp_n = 0;
    repeat (3) @(negedge clk);
    t_reset_R10();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_R10();
    t_plain_R2({1'b0, 11'd37, 1'b0, 8'd5}, "R2 plain read");
    t_plain_R2(21'h1FFFFF, "R1 all-ones address");
    t_seq_R5_R9();
    t_seq_one_R6();
    t_rand_R7();
    t_dual_R8();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule